// File: doc/BRIEF.md
# Byte-Wide Strobed Peripheral Register Port

This block is the peripheral end of a byte-wide parallel link: a host shares one 8-bit bidirectional bus for both register addresses and register data and tells the two apart only by which of two active-low strobes it pulls. An address strobe loads the bus byte into an internal address pointer. Each later data strobe either writes the bus byte into the selected register or, when the host has raised its direction line, makes the block drive the selected register's value onto the bus. Every cycle completes with a four-phase handshake on a wait line: the block raises it once it has seen the strobe and drops it only after the strobe has gone away.

The registers behind the port hold the settings of a three-phase edge-aligned PWM stage. These are one count per phase, the period divider, the dead time, the brake count and a general-purpose output byte. A read-only byte reports the live fault pins. A host-driven init line clears the logic. An interrupt input from the rest of the chip is registered and passed to the host. All host lines are asynchronous to the block clock and pass through two-flop synchronisers.

Top module: `epp_regif`

## Requirements
- R1: After rst_ni is released, wait_o and intr_o are 0, ad_io is high-impedance and every register output is 0.
- R2: A falling address strobe captures the bus byte into the address pointer. The pointer keeps that value across any number of later data cycles.
- R3: A data strobe with write_ni low writes the bus byte into the addressed register. The register map is as follows. Phase c of the PWM counts has its low byte at 0x10+4c and its high byte at 0x11+4c. The divider sits at 0x20 (low byte) and 0x21 (high byte). The dead time is at 0x24. The brake count sits at 0x28 (low byte) and 0x29 (high byte). The output byte is at 0x30. Phase c drives pwm_cnt_o[16c+15:16c].
- R4: A data strobe with write_ni high drives the addressed register value onto ad_io while the strobe stays active. At all other times ad_io is released to high-impedance.
- R5: wait_o rises only after a strobe has been seen. It stays high for as long as that strobe is held, and it falls after the strobe is released.
- R6: A write to an address outside the map changes no register, and a read from such an address returns 0x00.
- R7: Address 0x31 reads the current fault_i byte. Writes to 0x31 are ignored.
- R8: Holding init_ni low clears every register and the address pointer, and it ends any cycle in progress.
- R9: intr_o equals irq_i delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_ni | input | 1 | Host peripheral reset, active low, asynchronous |
| write_ni | input | 1 | Host cycle direction: 0 write, 1 read |
| astb_ni | input | 1 | Host address strobe, active low |
| dstb_ni | input | 1 | Host data strobe, active low |
| ad_io | inout | 8 | Shared address/data bus |
| wait_o | output | 1 | Handshake to host, high while a cycle is held |
| intr_o | output | 1 | Interrupt to host |
| irq_i | input | 1 | Interrupt request from the chip |
| fault_i | input | 8 | Live fault pin status |
| pwm_cnt_o | output | 48 | Per-phase PWM counts, 16 bits each |
| div_o | output | 16 | Period divider value |
| dead_o | output | 8 | Dead time value |
| brake_o | output | 16 | Brake PWM count |
| gpo_o | output | 8 | General-purpose output byte |

## Verification
The assertions check the handshake on every cycle. They confirm that wait_o rises only after a seen strobe, holds while the strobe is held and drops once no strobe is active. They also confirm that the bus is driven only inside a read cycle, that an off-map write leaves every register output unchanged, that init clears the registers, and that intr_o tracks irq_i. Only the bench scenarios can show the end-to-end effect of the address map. This covers a byte landing on the intended output slice, read-back through the bus, the live read-only fault byte, the persistence of the address across data cycles and the recovery after an init pulse.

// File: rtl/epp_regif_pkg.sv
package epp_regif_pkg;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_ADDR = 2'd1,
    HS_DWR  = 2'd2,
    HS_DRD  = 2'd3
  } hs_state_e;

  // register map
  localparam int PWM_BASE   = 'h10;
  localparam int PWM_STRIDE = 4;
  localparam int DIV_BASE   = 'h20;
  localparam int DT_BASE    = 'h24;
  localparam int BRK_BASE   = 'h28;
  localparam int GPO_ADDR   = 'h30;
  localparam int FLT_ADDR   = 'h31;

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int         WIDTH   = 2,
  parameter int         STAGES  = 2,
  parameter logic [0:0] RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] lvl_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= {WIDTH{RST_VAL}};
    end else begin
      stg_q[0] <= raw_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign lvl_o = stg_q[STAGES-1];

endmodule

// File: rtl/epp_hs.sv
module epp_hs
  import epp_regif_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic as_act_i,
  input  logic ds_act_i,
  input  logic wr_sel_i,
  output logic addr_cap_o,
  output logic data_wr_o,
  output logic data_rd_o,
  output logic oe_o,
  output logic wait_o
);

  hs_state_e state_q, state_d;
  logic      as_prev_q, ds_prev_q;
  logic      as_go, ds_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_prev_q <= 1'b0;
      ds_prev_q <= 1'b0;
    end else begin
      as_prev_q <= as_act_i;
      ds_prev_q <= ds_act_i;
    end
  end

  assign as_go = as_act_i & ~as_prev_q;
  assign ds_go = ds_act_i & ~ds_prev_q;

  always_comb begin
    state_d    = state_q;
    addr_cap_o = 1'b0;
    data_wr_o  = 1'b0;
    data_rd_o  = 1'b0;
    if (soft_rst_i) begin
      state_d = HS_IDLE;
    end else begin
      unique case (state_q)
        HS_IDLE: begin
          if (as_go) begin
            state_d    = HS_ADDR;
            addr_cap_o = 1'b1;
          end else if (ds_go) begin
            if (wr_sel_i) begin
              state_d   = HS_DWR;
              data_wr_o = 1'b1;
            end else begin
              state_d   = HS_DRD;
              data_rd_o = 1'b1;
            end
          end
        end
        HS_ADDR: if (!as_act_i) state_d = HS_IDLE;
        HS_DWR,
        HS_DRD:  if (!ds_act_i) state_d = HS_IDLE;
        default: state_d = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_IDLE;
    else         state_q <= state_d;
  end

  assign wait_o = (state_q != HS_IDLE);
  assign oe_o   = (state_q == HS_DRD) & ds_act_i;

  AST_WAIT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wait_o) |-> $past(as_act_i || ds_act_i)); // R5

  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_i && ((state_q == HS_ADDR && as_act_i) ||
                     (state_q != HS_IDLE && state_q != HS_ADDR && ds_act_i)))
    |=> wait_o); // R5

  AST_WAIT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && !as_act_i && !ds_act_i) |=> !wait_o); // R5

  AST_OE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> (wait_o && ds_act_i && !$past(data_wr_o))); // R4

endmodule

// File: rtl/epp_regbank.sv
module epp_regbank
  import epp_regif_pkg::*;
#(
  parameter int N_PWM = 3,
  parameter int CNT_W = 16,
  parameter int DIV_W = 16,
  parameter int DT_W  = 8,
  parameter int BRK_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   soft_rst_i,
  input  logic [7:0]             addr_i,
  input  logic                   wr_en_i,
  input  logic [7:0]             wdata_i,
  input  logic [7:0]             fault_i,
  output logic [7:0]             rdata_o,
  output logic [N_PWM*CNT_W-1:0] pwm_cnt_o,
  output logic [DIV_W-1:0]       div_o,
  output logic [DT_W-1:0]        dead_o,
  output logic [BRK_W-1:0]       brake_o,
  output logic [7:0]             gpo_o
);

  localparam int CNT_B   = (CNT_W + 7) / 8;
  localparam int DIV_B   = (DIV_W + 7) / 8;
  localparam int DT_B    = (DT_W + 7) / 8;
  localparam int BRK_B   = (BRK_W + 7) / 8;
  localparam int DIV_OFS = N_PWM * CNT_B;
  localparam int DT_OFS  = DIV_OFS + DIV_B;
  localparam int BRK_OFS = DT_OFS + DT_B;
  localparam int GPO_OFS = BRK_OFS + BRK_B;
  localparam int NSLOT   = GPO_OFS + 1;
  localparam int SLOT_W  = $clog2(NSLOT);

  logic [7:0]        slot_q [NSLOT];
  logic              dec_hit, dec_ro;
  logic [SLOT_W-1:0] dec_idx;

  // address decode
  always_comb begin
    dec_hit = 1'b0;
    dec_ro  = 1'b0;
    dec_idx = '0;
    for (int c = 0; c < N_PWM; c++) begin
      for (int b = 0; b < CNT_B; b++) begin
        if (int'(addr_i) == PWM_BASE + c * PWM_STRIDE + b) begin
          dec_hit = 1'b1;
          dec_idx = SLOT_W'(c * CNT_B + b);
        end
      end
    end
    for (int b = 0; b < DIV_B; b++) begin
      if (int'(addr_i) == DIV_BASE + b) begin
        dec_hit = 1'b1;
        dec_idx = SLOT_W'(DIV_OFS + b);
      end
    end
    for (int b = 0; b < DT_B; b++) begin
      if (int'(addr_i) == DT_BASE + b) begin
        dec_hit = 1'b1;
        dec_idx = SLOT_W'(DT_OFS + b);
      end
    end
    for (int b = 0; b < BRK_B; b++) begin
      if (int'(addr_i) == BRK_BASE + b) begin
        dec_hit = 1'b1;
        dec_idx = SLOT_W'(BRK_OFS + b);
      end
    end
    if (int'(addr_i) == GPO_ADDR) begin
      dec_hit = 1'b1;
      dec_idx = SLOT_W'(GPO_OFS);
    end
    if (int'(addr_i) == FLT_ADDR) begin
      dec_hit = 1'b1;
      dec_ro  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSLOT; s++) slot_q[s] <= '0;
    end else if (soft_rst_i) begin
      for (int s = 0; s < NSLOT; s++) slot_q[s] <= '0;
    end else if (wr_en_i && dec_hit && !dec_ro) begin
      slot_q[dec_idx] <= wdata_i;
    end
  end

  always_comb begin
    if (!dec_hit)    rdata_o = 8'h00;
    else if (dec_ro) rdata_o = fault_i;
    else             rdata_o = slot_q[dec_idx];
  end

  // output assembly
  for (genvar c = 0; c < N_PWM; c++) begin : g_pwm
    logic [CNT_B*8-1:0] cat;
    for (genvar b = 0; b < CNT_B; b++) begin : g_byte
      assign cat[b*8 +: 8] = slot_q[c*CNT_B + b];
    end
    assign pwm_cnt_o[c*CNT_W +: CNT_W] = cat[CNT_W-1:0];
  end

  logic [DIV_B*8-1:0] div_cat;
  logic [DT_B*8-1:0]  dt_cat;
  logic [BRK_B*8-1:0] brk_cat;

  for (genvar b = 0; b < DIV_B; b++) begin : g_div
    assign div_cat[b*8 +: 8] = slot_q[DIV_OFS + b];
  end
  for (genvar b = 0; b < DT_B; b++) begin : g_dt
    assign dt_cat[b*8 +: 8] = slot_q[DT_OFS + b];
  end
  for (genvar b = 0; b < BRK_B; b++) begin : g_brk
    assign brk_cat[b*8 +: 8] = slot_q[BRK_OFS + b];
  end

  assign div_o   = div_cat[DIV_W-1:0];
  assign dead_o  = dt_cat[DT_W-1:0];
  assign brake_o = brk_cat[BRK_W-1:0];
  assign gpo_o   = slot_q[GPO_OFS];

  AST_UNMAPPED_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !dec_hit && !soft_rst_i) |=>
    ($stable(pwm_cnt_o) && $stable(div_o) && $stable(dead_o) &&
     $stable(brake_o) && $stable(gpo_o))); // R6

  AST_RO_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && dec_ro && !soft_rst_i) |=> ($stable(gpo_o) && $stable(div_o))); // R7

  AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (pwm_cnt_o == '0 && div_o == '0 && dead_o == '0 &&
                    brake_o == '0 && gpo_o == '0)); // R8

endmodule

// File: rtl/epp_regif.sv
module epp_regif
  import epp_regif_pkg::*;
#(
  parameter int N_PWM = 3,
  parameter int CNT_W = 16,
  parameter int DIV_W = 16,
  parameter int DT_W  = 8,
  parameter int BRK_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   init_ni,
  input  logic                   write_ni,
  input  logic                   astb_ni,
  input  logic                   dstb_ni,
  inout  wire  [7:0]             ad_io,
  output logic                   wait_o,
  output logic                   intr_o,
  input  logic                   irq_i,
  input  logic [7:0]             fault_i,
  output logic [N_PWM*CNT_W-1:0] pwm_cnt_o,
  output logic [DIV_W-1:0]       div_o,
  output logic [DT_W-1:0]        dead_o,
  output logic [BRK_W-1:0]       brake_o,
  output logic [7:0]             gpo_o
);

  logic [3:0] sync_lvl;
  logic       as_act, ds_act, wr_sel, soft_rst;
  logic       addr_cap, data_wr, data_rd, bus_oe;
  logic [7:0] bus_in, addr_q, rd_q, rd_data;
  logic       intr_q;

  // all host lines idle high
  epp_sync #(.WIDTH(4), .STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({init_ni, write_ni, dstb_ni, astb_ni}),
    .lvl_o  (sync_lvl)
  );

  assign as_act   = ~sync_lvl[0];
  assign ds_act   = ~sync_lvl[1];
  assign wr_sel   = ~sync_lvl[2];
  assign soft_rst = ~sync_lvl[3];

  epp_hs u_hs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .as_act_i   (as_act),
    .ds_act_i   (ds_act),
    .wr_sel_i   (wr_sel),
    .addr_cap_o (addr_cap),
    .data_wr_o  (data_wr),
    .data_rd_o  (data_rd),
    .oe_o       (bus_oe),
    .wait_o     (wait_o)
  );

  assign bus_in = ad_io;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (soft_rst) addr_q <= '0;
    else if (addr_cap) addr_q <= bus_in;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (data_rd) rd_q <= rd_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) intr_q <= 1'b0;
    else         intr_q <= irq_i;
  end

  assign intr_o = intr_q;
  assign ad_io  = bus_oe ? rd_q : 8'hzz;

  epp_regbank #(
    .N_PWM (N_PWM),
    .CNT_W (CNT_W),
    .DIV_W (DIV_W),
    .DT_W  (DT_W),
    .BRK_W (BRK_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .addr_i     (addr_q),
    .wr_en_i    (data_wr),
    .wdata_i    (bus_in),
    .fault_i    (fault_i),
    .rdata_o    (rd_data),
    .pwm_cnt_o  (pwm_cnt_o),
    .div_o      (div_o),
    .dead_o     (dead_o),
    .brake_o    (brake_o),
    .gpo_o      (gpo_o)
  );

  AST_INTR_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (intr_o == $past(irq_i))); // R9

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_cap && !soft_rst) |=> $stable(addr_q)); // R2

endmodule

// File: tb/epp_regif_tb.sv
`timescale 1ns/1ps
module epp_regif_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_ni = 1'b1;
  logic        write_ni = 1'b1;
  logic        astb_ni = 1'b1;
  logic        dstb_ni = 1'b1;
  logic        irq_i = 1'b0;
  logic [7:0]  fault_i = 8'h00;
  logic [7:0]  tb_bus = 8'h00;
  logic        tb_drv = 1'b0;
  wire  [7:0]  ad_w;
  logic        wait_o, intr_o;
  logic [47:0] pwm_cnt_o;
  logic [15:0] div_o, brake_o;
  logic [7:0]  dead_o, gpo_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  assign ad_w = tb_drv ? tb_bus : 8'hzz;

  epp_regif u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_ni   (init_ni),
    .write_ni  (write_ni),
    .astb_ni   (astb_ni),
    .dstb_ni   (dstb_ni),
    .ad_io     (ad_w),
    .wait_o    (wait_o),
    .intr_o    (intr_o),
    .irq_i     (irq_i),
    .fault_i   (fault_i),
    .pwm_cnt_o (pwm_cnt_o),
    .div_o     (div_o),
    .dead_o    (dead_o),
    .brake_o   (brake_o),
    .gpo_o     (gpo_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_lvl(input logic lvl, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk_i);
      if (wait_o === lvl) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic addr_cycle(input logic [7:0] a);
    bit ok;
    @(negedge clk_i);
    tb_bus = a; tb_drv = 1'b1; write_ni = 1'b0;
    @(negedge clk_i);
    astb_ni = 1'b0;
    wait_lvl(1'b1, ok);
    chk("R5", "addr wait rise", 48'(ok), 48'd1);
    astb_ni = 1'b1;
    wait_lvl(1'b0, ok);
    chk("R5", "addr wait fall", 48'(ok), 48'd1);
    tb_drv = 1'b0; write_ni = 1'b1;
  endtask

  task automatic data_write(input logic [7:0] d);
    bit ok;
    @(negedge clk_i);
    tb_bus = d; tb_drv = 1'b1; write_ni = 1'b0;
    @(negedge clk_i);
    dstb_ni = 1'b0;
    wait_lvl(1'b1, ok);
    chk("R5", "write wait rise", 48'(ok), 48'd1);
    dstb_ni = 1'b1;
    wait_lvl(1'b0, ok);
    chk("R5", "write wait fall", 48'(ok), 48'd1);
    tb_drv = 1'b0; write_ni = 1'b1;
  endtask

  task automatic data_read(input string req, input logic [7:0] exp);
    bit ok;
    @(negedge clk_i);
    tb_drv = 1'b0; write_ni = 1'b1;
    @(negedge clk_i);
    dstb_ni = 1'b0;
    wait_lvl(1'b1, ok);
    chk("R5", "read wait rise", 48'(ok), 48'd1);
    chk(req, "read data", 48'(ad_w), 48'(exp));
    dstb_ni = 1'b1;
    wait_lvl(1'b0, ok);
    chk("R5", "read wait fall", 48'(ok), 48'd1);
    chk("R4", "bus released after read", {40'd0, ad_w}, {40'd0, 8'hzz});
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    addr_cycle(a);
    data_write(d);
  endtask

  task automatic t_reset();
    chk("R1", "wait", 48'(wait_o), 48'd0);
    chk("R1", "intr", 48'(intr_o), 48'd0);
    chk("R1", "bus", {40'd0, ad_w}, {40'd0, 8'hzz});
    chk("R1", "regs", {pwm_cnt_o}, 48'd0);
    chk("R1", "misc", {div_o, dead_o, brake_o, gpo_o}, 56'd0);
  endtask

  task automatic t_pwm();
    reg_wr(8'h10, 8'h34); reg_wr(8'h11, 8'h12);
    reg_wr(8'h14, 8'hCD); reg_wr(8'h15, 8'hAB);
    reg_wr(8'h18, 8'h01); reg_wr(8'h19, 8'h80);
    chk("R3", "pwm counts", pwm_cnt_o, 48'h8001_ABCD_1234);
    addr_cycle(8'h15);
    data_read("R4", 8'hAB);
    data_read("R2", 8'hAB); // pointer held across data cycles
    addr_cycle(8'h10);
    data_read("R4", 8'h34);
  endtask

  task automatic t_misc();
    reg_wr(8'h20, 8'h2C); reg_wr(8'h21, 8'h01);
    reg_wr(8'h24, 8'h12);
    reg_wr(8'h28, 8'h5A); reg_wr(8'h29, 8'hC3);
    reg_wr(8'h30, 8'hA5);
    chk("R3", "divider", 48'(div_o), 48'h012C);
    chk("R3", "dead", 48'(dead_o), 48'h12);
    chk("R3", "brake", 48'(brake_o), 48'hC35A);
    chk("R3", "gpo", 48'(gpo_o), 48'hA5);
    // second pointer write then same-address overwrite
    addr_cycle(8'h30);
    data_write(8'h3C);
    data_write(8'h0F);
    chk("R2", "gpo after two writes", 48'(gpo_o), 48'h0F);
  endtask

  task automatic t_unmapped();
    logic [47:0] pwm_before;
    pwm_before = pwm_cnt_o;
    reg_wr(8'h12, 8'hEE);
    reg_wr(8'hFF, 8'h77);
    chk("R6", "pwm unchanged", pwm_cnt_o, pwm_before);
    chk("R6", "misc unchanged", {div_o, dead_o, brake_o, gpo_o}, 56'h012C_12_C35A_0F);
    addr_cycle(8'h12);
    data_read("R6", 8'h00);
  endtask

  task automatic t_fault();
    fault_i = 8'h5A;
    reg_wr(8'h31, 8'hFF);
    chk("R7", "gpo untouched", 48'(gpo_o), 48'h0F);
    data_read("R7", 8'h5A);
    fault_i = 8'h81;
    data_read("R7", 8'h81);
  endtask

  task automatic t_hold();
    bit ok;
    addr_cycle(8'h24);
    @(negedge clk_i);
    dstb_ni = 1'b0;
    wait_lvl(1'b1, ok);
    chk("R5", "wait seen", 48'(ok), 48'd1);
    repeat (12) @(negedge clk_i);
    chk("R5", "wait held", 48'(wait_o), 48'd1);
    chk("R4", "bus driven while held", 48'(ad_w), 48'h12);
    dstb_ni = 1'b1;
    wait_lvl(1'b0, ok);
    chk("R5", "wait released", 48'(ok), 48'd1);
    chk("R4", "bus z after hold", {40'd0, ad_w}, {40'd0, 8'hzz});
  endtask

  task automatic t_init();
    @(negedge clk_i);
    init_ni = 1'b0;
    repeat (6) @(negedge clk_i);
    init_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R8", "pwm cleared", pwm_cnt_o, 48'd0);
    chk("R8", "misc cleared", {div_o, dead_o, brake_o, gpo_o}, 56'd0);
    chk("R8", "wait low", 48'(wait_o), 48'd0);
    data_read("R8", 8'h00); // pointer back at 0x00, unmapped
    reg_wr(8'h30, 8'h66);
    chk("R8", "writes work after init", 48'(gpo_o), 48'h66);
  endtask

  task automatic t_irq();
    @(negedge clk_i);
    irq_i = 1'b1;
    @(negedge clk_i);
    chk("R9", "intr set", 48'(intr_o), 48'd1);
    irq_i = 1'b0;
    @(negedge clk_i);
    chk("R9", "intr clear", 48'(intr_o), 48'd0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    t_reset();
    t_pwm();
    t_misc();
    t_unmapped();
    t_fault();
    t_hold();
    t_irq();
    t_init();
    repeat (4) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule